// File: doc/BRIEF.md
# Boot Image Copy Engine

This block keeps a short boot program in a small memory that stays powered while the rest of the processor subsystem sleeps. On request, it copies that program into the processor's instruction memory and then releases the processor so it can run it. Software fills the persistent memory one 32-bit word at a time through a word-addressed host port. The same port reaches five control words: a source word index inside the persistent memory, a destination word address in instruction memory, a word count, a status word and a control word.

A copy can start in two ways. Software can write the go bit of the control word, and the bit stays set until the copy ends, so software can poll it for completion. Software can also set an arm bit, and then every later power-up pulse repeats the same copy with no host action. During a copy the engine reads one word per clock from the persistent memory and writes it through its own instruction-memory write port. A hold output keeps the processor stopped for the whole transfer.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control word and the status word read 0, `cpu_hold` is 0, and `imem_we` stays 0 until a copy is started.
- R2: Host word addresses with the top bit set (0x100 to 0x1FF at default size) reach the persistent memory, which holds 256 words. A write stores `host_wdata`, and a read returns the stored word on `host_rdata` one clock after the read strobe.
- R3: Register word indices are control 0, source 1, destination 2, count 3 and status 4. Writing the control word with bit 31 set starts a copy. Word i, for i from 0 to count-1, is read from persistent index source+i and written to instruction address destination+i, with one write per clock in consecutive cycles.
- R4: Control bit 31 reads back 1 while a copy runs and 0 once it ends. A copy of N words ends N+1 clocks after the clock edge that starts it.
- R5: Status bit 0 reads 1 after a copy has finished. It is cleared on the clock edge that starts the next copy.
- R6: Control bit 30 is an arm flag that reads back as written. While it is set, a one-clock `pwr_up` pulse starts the same copy. While it is clear, `pwr_up` has no effect.
- R7: A count of 0 finishes one clock after the start, sets status bit 0 and makes no instruction-memory write.
- R8: `cpu_hold` is 1 from the start edge until the copy ends (N+1 clocks for N words), and every instruction-memory write falls inside that window.
- R9: While a copy runs, host writes to the control, source, destination and count words are ignored, and any further start request or `pwr_up` pulse is ignored.
- R10: The source index wraps modulo the persistent memory depth, so word 255 is followed by word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_waddr | input | 9 | Host word address; bit 8 selects the persistent memory, otherwise the register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid one clock after `host_rd` |
| pwr_up | input | 1 | Power-up event pulse |
| cpu_hold | output | 1 | Holds the processor while a copy runs |
| imem_we | output | 1 | Instruction-memory write enable |
| imem_addr | output | 12 | Instruction-memory word address |
| imem_wdata | output | 32 | Instruction-memory write data |

## Verification
Two triggers can arrive in the same clock: a software start and an armed power-up pulse. Either one can also land while a copy is already running. The bench drives the go-bit write and `pwr_up` in the same clock and expects exactly one copy, with exactly `count` writes and a hold window of `count`+1 clocks. It then pulses `pwr_up` and writes the control, source and count words in the middle of a long copy. It judges the result by the total write count, the hold length and the register readback after the copy ends.

// File: rtl/bce_pkg.sv
package bce_pkg;
  // register word indices on the host port
  localparam int REG_CTRL = 0;
  localparam int REG_SRC  = 1;
  localparam int REG_DST  = 2;
  localparam int REG_CNT  = 3;
  localparam int REG_STAT = 4;
  // control word fields
  localparam int BIT_GO   = 31;
  localparam int BIT_ARM  = 30;
endpackage

// File: rtl/bce_store.sv
module bce_store #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [WORDS];

  // host port: write and registered read
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  // copy port: registered read only
  always_ff @(posedge clk) begin
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/bce_regs.sv
module bce_regs
  import bce_pkg::*;
#(
  parameter int MW   = 8,
  parameter int IA_W = 12,
  parameter int CW   = 9,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            rd,
  input  logic            sel_reg,
  input  logic [MW-1:0]   idx,
  input  logic [DW-1:0]   wdata,
  input  logic            busy,
  input  logic            done,
  output logic [MW-1:0]   src_q,
  output logic [IA_W-1:0] dst_q,
  output logic [CW-1:0]   cnt_q,
  output logic            arm_q,
  output logic            sw_start,
  output logic [DW-1:0]   rdata_q
);
  logic          wr_ok;
  logic [DW-1:0] rd_mux;
  logic          unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ok    = wr && sel_reg && !busy;
  assign sw_start = wr_ok && (idx == MW'(REG_CTRL)) && wdata[BIT_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (wr_ok) begin
      case (idx)
        MW'(REG_CTRL): arm_q <= wdata[BIT_ARM];
        MW'(REG_SRC):  src_q <= wdata[MW-1:0];
        MW'(REG_DST):  dst_q <= wdata[IA_W-1:0];
        MW'(REG_CNT):  cnt_q <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      MW'(REG_CTRL): begin
        rd_mux[BIT_GO]  = busy;
        rd_mux[BIT_ARM] = arm_q;
      end
      MW'(REG_SRC):  rd_mux[MW-1:0]   = src_q;
      MW'(REG_DST):  rd_mux[IA_W-1:0] = dst_q;
      MW'(REG_CNT):  rd_mux[CW-1:0]   = cnt_q;
      MW'(REG_STAT): rd_mux[0]        = done;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd && sel_reg) rdata_q <= rd_mux;
  end

  // R9
  regs_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) &&
                               $stable(cnt_q) && $stable(arm_q)));
endmodule

// File: rtl/bce_mover.sv
module bce_mover #(
  parameter int MW   = 8,
  parameter int IA_W = 12,
  parameter int CW   = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_start,
  input  logic            pwr_up,
  input  logic            arm,
  input  logic [MW-1:0]   src,
  input  logic [IA_W-1:0] dst,
  input  logic [CW-1:0]   cnt,
  output logic            busy,
  output logic            done,
  output logic            rd_en,
  output logic [MW-1:0]   rd_addr,
  output logic            imem_we,
  output logic [IA_W-1:0] imem_addr
);
  logic [CW-1:0] pos;
  logic          trig;
  logic          issue;

  assign trig    = sw_start || (pwr_up && arm);
  assign issue   = busy && (pos != cnt);
  assign rd_en   = issue;
  assign rd_addr = src + pos[MW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pos       <= '0;
      imem_we   <= 1'b0;
      imem_addr <= '0;
    end else begin
      imem_we <= issue;
      if (issue) begin
        imem_addr <= dst + IA_W'(pos);
        pos       <= pos + 1'b1;
      end
      if (!busy && trig) begin
        busy <= 1'b1;
        done <= 1'b0;
        pos  <= '0;
      end else if (busy && !issue) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R8
  write_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    imem_we |-> busy);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_we && $past(imem_we)) |-> (imem_addr == IA_W'($past(imem_addr) + 1'b1)));
  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R5
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int MEM_BYTES = 1024,
  parameter int IA_W      = 12,
  parameter int DW        = 32,
  localparam int WORDS    = MEM_BYTES / (DW / 8),
  localparam int MW       = $clog2(WORDS),
  localparam int CW       = MW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [MW:0]     host_waddr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            pwr_up,
  output logic            cpu_hold,
  output logic            imem_we,
  output logic [IA_W-1:0] imem_addr,
  output logic [DW-1:0]   imem_wdata
);
  logic            mem_sel;
  logic [MW-1:0]   word;
  logic            rd_mem_q;
  logic [DW-1:0]   mem_q;
  logic [DW-1:0]   reg_q;
  logic [MW-1:0]   src;
  logic [IA_W-1:0] dst;
  logic [CW-1:0]   cnt;
  logic            arm;
  logic            sw_start;
  logic            busy;
  logic            done;
  logic            rd_en;
  logic [MW-1:0]   rd_addr;

  assign mem_sel = host_waddr[MW];
  assign word    = host_waddr[MW-1:0];

  bce_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk),
    .a_we(host_wr && mem_sel), .a_re(host_rd && mem_sel),
    .a_addr(word), .a_wdata(host_wdata), .a_q(mem_q),
    .b_re(rd_en), .b_addr(rd_addr), .b_q(imem_wdata)
  );

  bce_regs #(.MW(MW), .IA_W(IA_W), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .rd(host_rd), .sel_reg(!mem_sel),
    .idx(word), .wdata(host_wdata), .busy(busy), .done(done),
    .src_q(src), .dst_q(dst), .cnt_q(cnt), .arm_q(arm),
    .sw_start(sw_start), .rdata_q(reg_q)
  );

  bce_mover #(.MW(MW), .IA_W(IA_W), .CW(CW)) u_mover (
    .clk(clk), .rst(rst), .sw_start(sw_start), .pwr_up(pwr_up), .arm(arm),
    .src(src), .dst(dst), .cnt(cnt), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .imem_we(imem_we), .imem_addr(imem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_mem_q <= 1'b0;
    else if (host_rd) rd_mem_q <= mem_sel;
  end

  assign host_rdata = rd_mem_q ? mem_q : reg_q;
  assign cpu_hold   = busy;
endmodule

// File: tb/boot_copy_engine_test.sv
module boot_copy_engine_test;
  localparam int CLK_NS = 10;
  localparam int NV = 5;
  localparam int V_SRC [NV] = '{0, 3, 250, 17, 128};
  localparam int V_DST [NV] = '{0, 64, 128, 512, 4090};
  localparam int V_CNT [NV] = '{8, 1, 10, 33, 12};
  localparam int V_HOLD[NV] = '{9, 2, 11, 34, 13};

  logic clk = 0, rst = 1, host_wr = 0, host_rd = 0, pwr_up = 0;
  logic [8:0] host_waddr = '0;
  logic [31:0] host_wdata = '0, host_rdata, imem_wdata;
  logic cpu_hold, imem_we;
  logic [11:0] imem_addr;

  int n_chk = 0, n_fail = 0;
  int wr_count = 0, hold_cnt = 0, cyc = 0;
  logic [11:0] log_addr [300];
  logic [31:0] log_data [300];
  int          log_cyc  [300];

  boot_copy_engine uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_waddr(host_waddr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pwr_up(pwr_up), .cpu_hold(cpu_hold), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cpu_hold) hold_cnt = hold_cnt + 1;
    if (imem_we) begin
      if (wr_count < 300) begin
        log_addr[wr_count] = imem_addr;
        log_data[wr_count] = imem_wdata;
        log_cyc[wr_count]  = cyc;
      end
      wr_count = wr_count + 1;
    end
  end

  function automatic logic [31:0] pat(int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0001_0101);
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1; host_waddr = a;
    @(negedge clk);
    d = host_rdata; host_rd = 0;
  endtask

  task automatic pulse_pwr();
    @(negedge clk);
    pwr_up = 1;
    @(negedge clk);
    pwr_up = 0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    wr_count = 0; hold_cnt = 0;
  endtask

  task automatic check_copy(int s, int d, int n, string req);
    for (int i = 0; i < n && i < 300; i++) begin
      check(log_addr[i] == 12'(d + i), req, 32'(log_addr[i]), 32'(12'(d + i)));
      check(log_data[i] == pat((s + i) % 256), req, log_data[i], pat((s + i) % 256));
      if (i > 0) check(log_cyc[i] == log_cyc[i-1] + 1, req, log_cyc[i], log_cyc[i-1] + 1);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(9'd0, r);  check(r == 0, "R1 ctrl", r, 0);
    rd(9'd4, r);  check(r == 0, "R1 status", r, 0);
    check(cpu_hold == 0, "R1 hold", 32'(cpu_hold), 0);
    check(wr_count == 0, "R1 no write", wr_count, 0);

    // R2 fill persistent memory and read back
    for (int k = 0; k < 256; k++) wr(9'(256 + k), pat(k));
    rd(9'(256 + 0), r);   check(r == pat(0), "R2 word0", r, pat(0));
    rd(9'(256 + 100), r); check(r == pat(100), "R2 word100", r, pat(100));
    rd(9'(256 + 255), r); check(r == pat(255), "R2 word255", r, pat(255));

    // R3 R4 R5 R8 R10 vector table
    for (int v = 0; v < NV; v++) begin
      wr(9'd1, 32'(V_SRC[v]));
      wr(9'd2, 32'(V_DST[v]));
      wr(9'd3, 32'(V_CNT[v]));
      rd(9'd3, r); check(r == 32'(V_CNT[v]), "R3 cnt readback", r, 32'(V_CNT[v]));
      clear_log();
      wr(9'd0, 32'h8000_0000);
      repeat (V_CNT[v] + 4) @(negedge clk);
      check(wr_count == V_CNT[v], "R3 write count", wr_count, V_CNT[v]);
      check_copy(V_SRC[v], V_DST[v], V_CNT[v], (V_SRC[v] + V_CNT[v] > 256) ? "R10 wrap" : "R3 copy");
      check(hold_cnt == V_HOLD[v], "R8 R4 hold length", hold_cnt, V_HOLD[v]);
      rd(9'd0, r); check(r == 0, "R4 go cleared", r, 0);
      rd(9'd4, r); check(r == 1, "R5 done", r, 1);
    end

    // R7 zero count
    wr(9'd3, 0);
    clear_log();
    wr(9'd0, 32'h8000_0000);
    repeat (4) @(negedge clk);
    check(wr_count == 0, "R7 no write", wr_count, 0);
    check(hold_cnt == 1, "R7 hold one clock", hold_cnt, 1);
    rd(9'd4, r); check(r == 1, "R7 done", r, 1);

    // R4 R5 R9 long copy with interference, armed
    wr(9'd1, 0); wr(9'd2, 32'h100); wr(9'd3, 40);
    wr(9'd0, 32'h4000_0000);
    clear_log();
    wr(9'd0, 32'hC000_0000);
    rd(9'd0, r); check(r == 32'hC000_0000, "R4 go reads 1", r, 32'hC000_0000);
    rd(9'd4, r); check(r == 0, "R5 done cleared", r, 0);
    wr(9'd1, 9); wr(9'd3, 2); wr(9'd0, 32'h8000_0000); wr(9'd0, 0);
    pulse_pwr();
    repeat (45) @(negedge clk);
    check(wr_count == 40, "R9 one copy", wr_count, 40);
    check(hold_cnt == 41, "R9 hold", hold_cnt, 41);
    check_copy(0, 32'h100, 40, "R9 copy");
    rd(9'd1, r); check(r == 0, "R9 src kept", r, 0);
    rd(9'd3, r); check(r == 40, "R9 cnt kept", r, 40);
    rd(9'd0, r); check(r == 32'h4000_0000, "R9 arm kept", r, 32'h4000_0000);

    // R6 armed power-up then disarmed
    wr(9'd3, 6);
    clear_log();
    pulse_pwr();
    repeat (10) @(negedge clk);
    check(wr_count == 6, "R6 armed copy", wr_count, 6);
    check(hold_cnt == 7, "R6 armed hold", hold_cnt, 7);
    check_copy(0, 32'h100, 6, "R6 copy");
    wr(9'd0, 0);
    clear_log();
    pulse_pwr();
    repeat (10) @(negedge clk);
    check(wr_count == 0, "R6 disarmed write", wr_count, 0);
    check(hold_cnt == 0, "R6 disarmed hold", hold_cnt, 0);

    // R6 R9 same-cycle software start and power-up
    wr(9'd0, 32'h4000_0000);
    wr(9'd3, 5);
    clear_log();
    @(negedge clk);
    host_wr = 1; host_waddr = 9'd0; host_wdata = 32'hC000_0000; pwr_up = 1;
    @(negedge clk);
    host_wr = 0; pwr_up = 0;
    repeat (10) @(negedge clk);
    check(wr_count == 5, "R9 same-cycle single copy", wr_count, 5);
    check(hold_cnt == 6, "R9 same-cycle hold", hold_cnt, 6);

    summary();
  end
endmodule